// File: doc/BRIEF.md
# I2C SCL Two-Phase Timing Generator

This block produces the SCL waveform for an I2C master. The lengths of the low and high phases come from two configuration words. Each word holds two counts: one for the fast and standard rates and one for the high-speed rate. The hardware adds a fixed amount to each count. A low phase lasts the low count plus seven ticks, and a high phase lasts the high count plus five ticks.

At standard and fast rates a tick is one pulse of a prescaled enable input. At the high-speed rate a tick is every cycle of the functional clock. A high-speed transfer begins at fast-rate timing, which carries the master code. When the protocol engine requests the change to high-speed timing, the generator waits for the current low phase to complete. It then moves to the high-speed counts and the functional clock, so no SCL pulse is ever shortened.

Deasserting `run` lets the current phase finish. The generator then leaves SCL high. Single-cycle strobes mark every falling and rising edge of SCL.

Top module: `scl_two_phase_gen`

## Requirements
- R1: In fast/standard timing, every SCL low phase lasts (fsLow + 7) pulses of `tickEn`.
- R2: In fast/standard timing, every SCL high phase lasts (fsHigh + 5) pulses of `tickEn`.
- R3: After the switch to high-speed timing, low phases last (hsLow + 7) clock cycles and high phases last (hsHigh + 5) clock cycles, independent of `tickEn`.
- R4: In each configuration word, the fast/standard count sits in bits [7:0] and the high-speed count sits in bits [15:8].
- R5: With `hsMode` high and no switch requested, the generator uses the fast/standard counts and `tickEn`.
- R6: A switch request (`phaseReq` high for a cycle while `hsMode` is high) takes effect only at the end of a low phase. A request made during a low phase applies at the end of that low phase. A request made during a high phase applies at the end of the next low phase. That low phase keeps its full fast/standard length, and the high phase that follows uses high-speed timing.
- R7: When `hsMode` is low, `phaseReq` has no effect and all phases keep fast/standard timing.
- R8: When `run` is deasserted, the current phase completes. If it is a low phase, the high phase that follows also completes. SCL then stays high with no further falling edge.
- R9: When `run` is asserted from idle, SCL falls at the next tick. A restart after a stop uses fast/standard timing again.
- R10: `fallStrobe` is high for exactly the first cycle in which `sclOut` is low, and `riseStrobe` is high for exactly the first cycle in which `sclOut` is high again. The two never assert together.
- R11: While in reset and right after it, `sclOut` is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Prescaled tick enable for fast/standard timing |
| cfgLow | input | 16 | Low-phase counts: [15:8] high-speed, [7:0] fast/standard |
| cfgHigh | input | 16 | High-phase counts: [15:8] high-speed, [7:0] fast/standard |
| hsMode | input | 1 | Transfer is a two-phase high-speed transfer |
| phaseReq | input | 1 | Request to move to high-speed timing |
| run | input | 1 | Keep clocking SCL while high |
| sclOut | output | 1 | SCL level: 0 drives low, 1 releases high |
| fallStrobe | output | 1 | One-cycle pulse at each SCL falling edge |
| riseStrobe | output | 1 | One-cycle pulse at each SCL rising edge |

## Verification
The hardest case is the phase switch landing exactly on a low-phase boundary. The request has to be held pending across a high phase and applied only when the next low phase ends. The bench handles this by synchronising to the first rise strobe and to the first fall strobe, and by pulsing `phaseReq` for one cycle at each of those points. It then measures every later phase in cycles. Using distinct counts in the upper and lower fields, together with a slow tick, keeps the fast/standard lengths and the high-speed lengths far apart, so a switch one phase early or one phase late shows up directly.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } sclState_e;

  // strobes from control to the phase counter
  typedef struct packed {
    logic advance;   // one tick of the active time base
    logic loadLow;   // start a low phase
    logic loadHigh;  // start a high phase
    logic useHs;     // select the high-speed field for the load
  } cntCtrl_t;

endpackage

// File: rtl/scl_phase_counter.sv
module scl_phase_counter
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W  = 8,
  parameter int HS_POS   = 8,
  parameter int CFG_W    = 16,
  parameter int LOW_ADD  = 7,
  parameter int HIGH_ADD = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfgLow,
  input  logic [CFG_W-1:0] cfgHigh,
  input  cntCtrl_t         ctl,
  output logic             cntZero
);

  localparam int MAX_ADD = (LOW_ADD > HIGH_ADD) ? LOW_ADD : HIGH_ADD;
  localparam int CNT_W   = $clog2((1 << FIELD_W) + MAX_ADD);
  localparam int CNT_MAX = (1 << FIELD_W) - 1 + MAX_ADD - 1;

  logic [FIELD_W-1:0] lowField;
  logic [FIELD_W-1:0] highField;
  logic [CNT_W-1:0]   lowLoad;
  logic [CNT_W-1:0]   highLoad;
  logic [CNT_W-1:0]   cnt;

  // field select: upper field for high-speed, lower for fast/standard
  always_comb begin
    if (ctl.useHs) begin
      lowField  = cfgLow[HS_POS +: FIELD_W];
      highField = cfgHigh[HS_POS +: FIELD_W];
    end else begin
      lowField  = cfgLow[FIELD_W-1:0];
      highField = cfgHigh[FIELD_W-1:0];
    end
  end

  // the counter holds remaining ticks minus one
  assign lowLoad  = CNT_W'(lowField)  + CNT_W'(LOW_ADD - 1);
  assign highLoad = CNT_W'(highField) + CNT_W'(HIGH_ADD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ctl.loadLow) begin
      cnt <= lowLoad;
    end else if (ctl.loadHigh) begin
      cnt <= highLoad;
    end else if (ctl.advance && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  // an expired count never wraps unless a new phase is loaded
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cntZero && !ctl.loadLow && !ctl.loadHigh) |=> cntZero);

  // the count stays within the longest phase
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tickEn,
  input  logic     hsMode,
  input  logic     phaseReq,
  input  logic     run,
  input  logic     cntZero,
  output cntCtrl_t ctl,
  output logic     sclOut,
  output logic     fallStrobe,
  output logic     riseStrobe
);

  sclState_e state, nState;
  logic      hsPhase, nHs;
  logic      pendSw, nPend;
  logic      adv, reqNow, goFall, goRise;

  assign adv    = hsPhase | tickEn;
  assign reqNow = hsMode & phaseReq & ~hsPhase;

  always_comb begin
    nState      = state;
    nHs         = hsPhase;
    nPend       = pendSw;
    goFall      = 1'b0;
    goRise      = 1'b0;
    ctl         = '0;
    ctl.advance = adv;
    ctl.useHs   = hsPhase;
    unique case (state)
      ST_IDLE: begin
        nHs   = 1'b0;
        nPend = 1'b0;
        if (run && adv) begin
          nState      = ST_LOW;
          ctl.loadLow = 1'b1;
          ctl.useHs   = 1'b0;
          goFall      = 1'b1;
        end
      end
      ST_LOW: begin
        if (reqNow) nPend = 1'b1;
        if (adv && cntZero) begin
          nState       = ST_HIGH;
          ctl.loadHigh = 1'b1;
          goRise       = 1'b1;
          if (nPend) begin
            nHs       = 1'b1;
            nPend     = 1'b0;
            ctl.useHs = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (reqNow) nPend = 1'b1;
        if (adv && cntZero) begin
          if (run) begin
            nState      = ST_LOW;
            ctl.loadLow = 1'b1;
            goFall      = 1'b1;
          end else begin
            nState = ST_IDLE;
            nHs    = 1'b0;
            nPend  = 1'b0;
          end
        end
      end
      default: begin
        nState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      hsPhase    <= 1'b0;
      pendSw     <= 1'b0;
      sclOut     <= 1'b1;
      fallStrobe <= 1'b0;
      riseStrobe <= 1'b0;
    end else begin
      state      <= nState;
      hsPhase    <= nHs;
      pendSw     <= nPend;
      sclOut     <= (nState != ST_LOW);
      fallStrobe <= goFall;
      riseStrobe <= goRise;
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fallStrobe && riseStrobe));

  assert_fall_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fallStrobe |-> (!sclOut && $past(sclOut)));

  assert_rise_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    riseStrobe |-> (sclOut && !$past(sclOut)));

  // timing base changes only together with a rising SCL edge
  assert_switch_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsPhase) |-> riseStrobe);

  assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pendSw) |-> $past(hsMode));

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && !run && adv && cntZero) |=>
      (state == ST_IDLE && sclOut && !fallStrobe));

endmodule

// File: rtl/scl_two_phase_gen.sv
module scl_two_phase_gen
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W  = 8,
  parameter int HS_POS   = 8,
  parameter int CFG_W    = 16,
  parameter int LOW_ADD  = 7,
  parameter int HIGH_ADD = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic [CFG_W-1:0] cfgLow,
  input  logic [CFG_W-1:0] cfgHigh,
  input  logic             hsMode,
  input  logic             phaseReq,
  input  logic             run,
  output logic             sclOut,
  output logic             fallStrobe,
  output logic             riseStrobe
);

  cntCtrl_t cntCtl;
  logic     cntZero;

  scl_phase_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tickEn     (tickEn),
    .hsMode     (hsMode),
    .phaseReq   (phaseReq),
    .run        (run),
    .cntZero    (cntZero),
    .ctl        (cntCtl),
    .sclOut     (sclOut),
    .fallStrobe (fallStrobe),
    .riseStrobe (riseStrobe)
  );

  scl_phase_counter #(
    .FIELD_W  (FIELD_W),
    .HS_POS   (HS_POS),
    .CFG_W    (CFG_W),
    .LOW_ADD  (LOW_ADD),
    .HIGH_ADD (HIGH_ADD)
  ) counter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfgLow  (cfgLow),
    .cfgHigh (cfgHigh),
    .ctl     (cntCtl),
    .cntZero (cntZero)
  );

endmodule

// File: tb/scl_two_phase_gen_tb_top.sv
`timescale 1ns/1ps
module scl_two_phase_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b0;
  logic [15:0] cfgLow = '0;
  logic [15:0] cfgHigh = '0;
  logic        hsMode = 1'b0;
  logic        phaseReq = 1'b0;
  logic        run = 1'b0;
  logic        sclOut, fallStrobe, riseStrobe;

  int checks = 0;
  int failures = 0;
  int tickPer = 3;
  int tickCnt = 0;
  int cycles = 0;
  bit done = 1'b0;

  bit isLowQ[$];
  int lenQ[$];
  bit prevScl = 1'b1;
  int runLen = 0;

  always #10 clk = ~clk;

  scl_two_phase_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .cfgLow(cfgLow),
    .cfgHigh(cfgHigh), .hsMode(hsMode), .phaseReq(phaseReq), .run(run),
    .sclOut(sclOut), .fallStrobe(fallStrobe), .riseStrobe(riseStrobe)
  );

  // tick enable: one pulse every tickPer cycles
  always @(posedge clk) begin
    #2;
    if (tickCnt >= tickPer - 1) begin
      tickCnt = 0;
      tickEn  = 1'b1;
    end else begin
      tickCnt = tickCnt + 1;
      tickEn  = 1'b0;
    end
  end

  // phase recorder and strobe checker
  always @(negedge clk) begin
    if (rst_n) begin
      checks = checks + 1;
      if (fallStrobe !== (prevScl && !sclOut) || riseStrobe !== (!prevScl && sclOut)) begin
        failures = failures + 1;
        $display("FAIL R10 strobes fall=%0b rise=%0b expected fall=%0b rise=%0b",
                 fallStrobe, riseStrobe, prevScl && !sclOut, !prevScl && sclOut);
      end
      if (sclOut == prevScl) begin
        runLen = runLen + 1;
      end else begin
        isLowQ.push_back(!prevScl);
        lenQ.push_back(runLen);
        runLen = 1;
      end
      prevScl = sclOut;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 190000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic stepCyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // start the clock and drop the idle entry of the recorder
  task automatic startRun();
    run = 1'b1;
    do stepCyc(1); while (!fallStrobe);
    @(negedge clk);
    #1;
    isLowQ.delete();
    lenQ.delete();
  endtask

  task automatic waitPhases(int n);
    while (lenQ.size() < n) stepCyc(1);
  endtask

  task automatic stopRun(int tail);
    run = 1'b0;
    stepCyc(tail);
  endtask

  task automatic checkPhase(int idx, bit expLow, int expLen, string tag);
    check(idx < lenQ.size() && isLowQ[idx] == expLow && lenQ[idx] == expLen,
          $sformatf("%s phase%0d low=%0b", tag, idx, expLow),
          (idx < lenQ.size()) ? lenQ[idx] : -1, expLen);
  endtask

  initial begin
    int lowVals[5]  = '{0, 1, 2, 100, 255};
    int highVals[3] = '{0, 3, 255};
    int lat;
    int falls;
    stepCyc(3);
    // R11: reset state
    check(sclOut === 1'b1, "R11 scl in reset", sclOut, 1);
    check(fallStrobe === 1'b0 && riseStrobe === 1'b0, "R11 strobes in reset",
          fallStrobe | riseStrobe, 0);
    rst_n = 1'b1;
    stepCyc(4);
    check(sclOut === 1'b1, "R11 scl after reset", sclOut, 1);

    // R1 R2 R4: fast/standard sweep, upper fields hold other values
    tickPer = 3;
    foreach (lowVals[i]) begin
      foreach (highVals[j]) begin
        cfgLow  = {8'(~lowVals[i]), 8'(lowVals[i])};
        cfgHigh = {8'(~highVals[j]), 8'(highVals[j])};
        startRun();
        waitPhases(3);
        stopRun((lowVals[i] + highVals[j] + 12) * 3 * 2 + 10);
        checkPhase(0, 1'b1, (lowVals[i] + 7) * 3, "R1 R4 fs low");
        checkPhase(1, 1'b0, (highVals[j] + 5) * 3, "R2 R4 fs high");
        checkPhase(2, 1'b1, (lowVals[i] + 7) * 3, "R1 fs low repeat");
      end
    end

    // R7: request ignored without hsMode
    tickPer = 4;
    cfgLow  = 16'h020A;
    cfgHigh = 16'h0004;
    hsMode  = 1'b0;
    startRun();
    do stepCyc(1); while (!riseStrobe);
    phaseReq = 1'b1;
    stepCyc(1);
    phaseReq = 1'b0;
    waitPhases(5);
    stopRun(400);
    checkPhase(2, 1'b1, 68, "R7 low after ignored request");
    checkPhase(3, 1'b0, 36, "R7 high after ignored request");
    checkPhase(4, 1'b1, 68, "R7 later low");

    // R5 R6 R3: request during a high phase
    hsMode = 1'b1;
    startRun();
    do stepCyc(1); while (!riseStrobe);
    phaseReq = 1'b1;
    stepCyc(1);
    phaseReq = 1'b0;
    waitPhases(8);
    stopRun(200);
    checkPhase(0, 1'b1, 68, "R5 first low fs");
    checkPhase(1, 1'b0, 36, "R5 high holding request");
    checkPhase(2, 1'b1, 68, "R6 low completes at fs");
    checkPhase(3, 1'b0, 5,  "R6 R3 first hs high");
    checkPhase(4, 1'b1, 9,  "R3 hs low");
    checkPhase(5, 1'b0, 5,  "R3 hs high");
    checkPhase(6, 1'b1, 9,  "R3 hs low repeat");

    // R6 R9: request during a low phase, after a stop (restart is fs)
    startRun();
    phaseReq = 1'b1;
    stepCyc(1);
    phaseReq = 1'b0;
    waitPhases(4);
    stopRun(200);
    checkPhase(0, 1'b1, 68, "R6 R9 low completes at fs after restart");
    checkPhase(1, 1'b0, 5,  "R6 hs high after low request");
    checkPhase(2, 1'b1, 9,  "R3 hs low after low request");
    checkPhase(3, 1'b0, 5,  "R3 hs high after low request");

    // R8: stop during a low phase
    hsMode  = 1'b0;
    tickPer = 2;
    cfgLow  = 16'h0003;
    cfgHigh = 16'h0001;
    startRun();
    run = 1'b0;
    falls = 0;
    for (int k = 0; k < 300; k++) begin
      stepCyc(1);
      if (fallStrobe) falls = falls + 1;
    end
    check(lenQ.size() == 1, "R8 phases after stop", lenQ.size(), 1);
    checkPhase(0, 1'b1, 20, "R8 low completes after stop");
    check(falls == 0, "R8 no fall after stop", falls, 0);
    check(sclOut === 1'b1, "R8 scl released", sclOut, 1);

    // R9: start latency from idle
    tickPer = 5;
    stepCyc(7);
    run = 1'b1;
    lat = 0;
    do begin stepCyc(1); lat = lat + 1; end while (!fallStrobe && lat < 50);
    check(lat >= 1 && lat <= 6, "R9 start latency", lat, 6);
    stopRun(200);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule